// File: doc/BRIEF.md
# Five-level noise-shaping modulator

This block converts a stream of signed 21-bit audio words, delivered by an upstream 8x interpolation stage, into a 5-level code for a multi-level analog converter. One instance serves one stereo channel. A third-order loop of three delay-based integrators with distributed quantizer feedback pushes quantization noise out of the audio band. The noise transfer function is (z-1)^3/(z-0.5)^3, and every coefficient is a shift or a sum of two shifts. The quantizer produces codes 0 to 4 for levels -2..+2 times a step Q of 2^(IN_W-2), so full scale (2^(IN_W-1)) equals two steps. Every integrator saturates instead of wrapping, so an overload clamps and later recovers.

The modulator advances one step on each clock where `ce_i` is high. It normally runs at 8 steps per input word. A word on `sample_i` is captured only when `strobe_i` is high, and it is held until the next strobe. A small control FSM gates the loop and has three states. HALT is entered on reset or mute; the integrators are cleared there and the output is mid-scale. ARM is entered from HALT when mute is low; it waits for the first strobe, with the integrators cleared and the output at mid-scale. RUN is entered from ARM on a strobe, and the loop runs there. The named transitions are HALT->ARM (mute released), ARM->RUN (strobe), ARM->HALT (mute) and RUN->HALT (mute).

Top module: `dsm5_shaper`

## Requirements
- R1: In the first cycle after synchronous reset is released, `code_o` is 2 (bipolar zero).
- R2: While mute is high, `code_o` is 2 from the cycle after mute is seen. After mute is released, all integrator state has been cleared: with a zero input word, every later code is exactly 2.
- R3: After reset or mute, the loop does not start before the first strobe. Until then `code_o` stays 2 whatever the input word is.
- R4: `code_o` only takes the values 0, 1, 2, 3 and 4, where code k stands for level (k-2)*Q and Q = 2^(IN_W-2).
- R5: In the RUN state, a clock with `ce_i` low changes neither the loop state nor `code_o`.
- R6: `sample_i` is captured only in cycles with `strobe_i` high. Values present between strobes have no effect on the output.
- R7: For a constant input word x with |x| <= 0.75 full scale, the mean code over 2048 steps equals 2 + x/Q within 0.06.
- R8: On an input at the positive or negative full-scale limit, the codes settle at 4 or 0 respectively, and no integrator wraps. When the input returns inside range, the mean code again meets R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ce_i | input | 1 | Modulator step enable |
| strobe_i | input | 1 | Input word valid; loads `sample_i` |
| sample_i | input | IN_W | Signed input word (two's complement) |
| mute_i | input | 1 | Forces mid-scale output and clears the loop |
| code_o | output | 3 | Quantizer code 0..4, 2 = bipolar zero |

## Verification
A wrong coefficient, a wrong threshold or a lost feedback term leaves the codes bounded, but it moves their long-run average. The average over a 2048-step window then departs from 2 + x/Q. A wrapping integrator shows as codes at the opposite extreme during a full-scale input, within a few hundred steps. An integrator left uncleared by mute shows as non-mid codes in the very first steps after mute is released with zero input. A strobe that is ignored, or a sample that is not held, shows as a mean tracking the scrambled between-strobe values. A clock-enable fault shows as a code that moves during a stall.

// File: rtl/dsm5_pkg.sv
package dsm5_pkg;

    typedef logic [2:0] code_t;

    localparam code_t CODE_MID = 3'd2;
    localparam code_t CODE_TOP = 3'd4;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } mod_state_t;

    // Signed level -2..+2 for code 0..4 (3-bit wrap gives the right result)
    function automatic logic signed [2:0] level_of(input code_t c);
        return $signed(c) - 3'sd2;
    endfunction

endpackage

// File: rtl/dsm5_ctrl.sv
module dsm5_ctrl
    import dsm5_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic mute_i,
    input  logic strobe_i,
    output logic run_o
);

    mod_state_t state_q;
    mod_state_t state_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (!mute_i) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (mute_i)        state_d = ST_HALT;
                else if (strobe_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (mute_i) state_d = ST_HALT;
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_comb begin
        run_o = (state_q == ST_RUN);
    end

endmodule

// File: rtl/dsm5_integ.sv
module dsm5_integ #(
    parameter int AW = 25,
    parameter int DW = 26
) (
    input  logic                 clk_i,
    input  logic                 clr_i,
    input  logic                 en_i,
    input  logic signed [DW-1:0] d_i,
    output logic signed [AW-1:0] acc_o
);

    localparam int SW = DW + 1;
    localparam logic signed [SW-1:0] HI = SW'({1'b0, {(AW-1){1'b1}}});
    localparam logic signed [SW-1:0] LO = -HI - SW'(1);

    logic signed [AW-1:0] acc_q;
    logic signed [SW-1:0] sum_w;
    logic signed [AW-1:0] nxt_w;

    assign sum_w = SW'(acc_q) + SW'(d_i);

    // Clamp to the accumulator range instead of wrapping
    always_comb begin
        if (sum_w > HI)      nxt_w = HI[AW-1:0];
        else if (sum_w < LO) nxt_w = LO[AW-1:0];
        else                 nxt_w = sum_w[AW-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            acc_q <= '0;
        end else if (en_i) begin
            acc_q <= nxt_w;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/dsm5_quant.sv
module dsm5_quant
    import dsm5_pkg::*;
#(
    parameter int AW  = 25,
    parameter int QSH = 19
) (
    input  logic signed [AW-1:0] acc_i,
    output code_t                code_o
);

    localparam longint HALF = longint'(1) << (QSH - 1);
    localparam logic signed [AW-1:0] T_P3 = AW'(3 * HALF);
    localparam logic signed [AW-1:0] T_P1 = AW'(HALF);
    localparam logic signed [AW-1:0] T_N1 = AW'(-HALF);
    localparam logic signed [AW-1:0] T_N3 = AW'(-3 * HALF);

    // Nearest of five levels spaced 2*HALF apart; ties round upward
    always_comb begin
        if (acc_i >= T_P3)      code_o = 3'd4;
        else if (acc_i >= T_P1) code_o = 3'd3;
        else if (acc_i >= T_N1) code_o = 3'd2;
        else if (acc_i >= T_N3) code_o = 3'd1;
        else                    code_o = 3'd0;
    end

endmodule

// File: rtl/dsm5_shaper.sv
module dsm5_shaper
    import dsm5_pkg::*;
#(
    parameter int IN_W  = 21,
    parameter int GUARD = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   ce_i,
    input  logic                   strobe_i,
    input  logic signed [IN_W-1:0] sample_i,
    input  logic                   mute_i,
    output logic [2:0]             code_o
);

    localparam int ACC_W = IN_W + GUARD;
    localparam int DW    = ACC_W + 1;
    localparam int QSH   = IN_W - 2;
    localparam int NST   = 3;
    localparam int A1_SH = 3;

    logic signed [IN_W-1:0] samp_q;
    logic                   run_w;
    logic                   clr_w;
    logic                   step_w;
    code_t                  qcode_w;
    logic signed [2:0]      lvl_w;
    logic signed [DW-1:0]   fb_w;
    logic signed [DW-1:0]   u_w;
    logic signed [ACC_W-1:0] st [NST];
    logic signed [DW-1:0]    din [NST];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            samp_q <= '0;
        end else if (strobe_i) begin
            samp_q <= sample_i;
        end
    end

    dsm5_ctrl u_ctrl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .mute_i   (mute_i),
        .strobe_i (strobe_i),
        .run_o    (run_w)
    );

    assign clr_w  = rst_i | mute_i | ~run_w;
    assign step_w = ce_i & run_w;

    assign lvl_w = level_of(qcode_w);
    assign fb_w  = DW'(lvl_w) <<< QSH;
    assign u_w   = DW'(samp_q);

    // Loop coefficients 1/8, 3/4, 3/2: all three loop poles at z = 0.5
    assign din[0] = (u_w - fb_w) >>> A1_SH;
    assign din[1] = DW'(st[0]) - ((fb_w >>> 1) + (fb_w >>> 2));
    assign din[2] = DW'(st[1]) - (fb_w + (fb_w >>> 1));

    for (genvar g = 0; g < NST; g++) begin : g_stage
        dsm5_integ #(
            .AW (ACC_W),
            .DW (DW)
        ) u_int (
            .clk_i (clk_i),
            .clr_i (clr_w),
            .en_i  (step_w),
            .d_i   (din[g]),
            .acc_o (st[g])
        );
    end

    dsm5_quant #(
        .AW  (ACC_W),
        .QSH (QSH)
    ) u_quant (
        .acc_i  (st[NST-1]),
        .code_o (qcode_w)
    );

    assign code_o = run_w ? qcode_w : CODE_MID;

endmodule

// File: rtl/dsm5_shaper_chk.sv
module dsm5_shaper_chk
    import dsm5_pkg::*;
(
    input logic  clk_i,
    input logic  rst_i,
    input logic  mute_i,
    input logic  ce_i,
    input logic  strobe_i,
    input logic  run_i,
    input code_t code_o
);

    // R1
    reset_mid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> code_o == CODE_MID);

    // R2
    mute_mid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        mute_i |=> code_o == CODE_MID);

    // R3
    arm_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(run_i) |-> $past(strobe_i));

    // R4
    code_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        code_o <= CODE_TOP);

    // R5
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && !ce_i && !mute_i) |=> $stable(code_o));

endmodule

bind dsm5_shaper dsm5_shaper_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .mute_i   (mute_i),
    .ce_i     (ce_i),
    .strobe_i (strobe_i),
    .run_i    (run_w),
    .code_o   (code_o)
);

// File: tb/dsm5_shaper_bench.sv
module dsm5_shaper_bench;

    localparam int  IN_W = 21;
    localparam real QV   = 524288.0;
    localparam real TOL  = 0.06;

    typedef struct {
        string req;
        real   lo;
        real   hi;
        bit    every;
    } item_t;

    logic                   clk = 1'b0;
    logic                   rst_i = 1'b1;
    logic                   ce_i = 1'b0;
    logic                   strobe_i = 1'b0;
    logic signed [IN_W-1:0] sample_i = '0;
    logic                   mute_i = 1'b0;
    logic [2:0]             code_o;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    int    steps = 0;
    int    cur_sample = 0;
    bit    ce_en = 1'b1;
    bit    strobe_en = 1'b0;
    bit    win_go = 1'b0;
    int    win_len = 0;
    int    gmax = 0;
    item_t exp_q[$];

    always #4 clk = ~clk;

    dsm5_shaper u_dsm5_shaper (
        .clk_i    (clk),
        .rst_i    (rst_i),
        .ce_i     (ce_i),
        .strobe_i (strobe_i),
        .sample_i (sample_i),
        .mute_i   (mute_i),
        .code_o   (code_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0.4f expected=%0.4f", req, what, act, expv);
        end
    endtask

    // Stimulus clocking: enable with stalls, strobe every 8 steps,
    // scrambled data on sample_i between strobes (R6)
    always @(negedge clk) begin
        cyc++;
        ce_i = ce_en && ((cyc % 4) != 3);
        if (ce_i && strobe_en && ((steps % 8) == 0)) begin
            strobe_i = 1'b1;
            sample_i = IN_W'(cur_sample);
        end else begin
            strobe_i = 1'b0;
            sample_i = IN_W'(cur_sample) ^ 21'h0AAAAA;
        end
        if (ce_i) steps++;
    end

    // Monitor: collect codes of every step in a window, pop and compare
    initial begin
        int  n = 0;
        int  sum = 0;
        int  mn = 99;
        int  mx = -1;
        bit  ce_at;
        forever begin
            @(posedge clk);
            ce_at = ce_i;
            #2;
            if (win_go && ce_at) begin
                int c;
                c = int'(code_o);
                sum += c;
                n++;
                if (c < mn) mn = c;
                if (c > mx) mx = c;
                if (c > gmax) gmax = c;
                if (n == win_len) begin
                    item_t it;
                    real   mean;
                    it = exp_q.pop_front();
                    mean = real'(sum) / real'(n);
                    if (it.every) begin
                        chk(mn >= it.lo && mx <= it.hi, it.req, "min code", real'(mn), it.lo);
                    end else begin
                        chk(mean >= it.lo && mean <= it.hi, it.req, "mean code", mean,
                            (it.lo + it.hi) / 2.0);
                    end
                    n = 0; sum = 0; mn = 99; mx = -1;
                    win_go = 1'b0;
                end
            end
        end
    end

    task automatic expect_win(input string req, input int smp, input real lo, input real hi,
                              input bit every, input int settle, input int len);
        item_t it;
        cur_sample = smp;
        repeat (settle) @(posedge clk);
        @(negedge clk);
        it.req = req; it.lo = lo; it.hi = hi; it.every = every;
        exp_q.push_back(it);
        win_len = len;
        win_go = 1'b1;
        wait (win_go == 1'b0);
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int smp_list[6] = '{0, 262144, -629146, 157286, 786432, -786432};
        logic [2:0] c0;

        repeat (5) @(negedge clk);
        rst_i = 1'b0;
        @(negedge clk);
        chk(code_o == 3'd2, "R1", "code after reset", real'(code_o), 2.0);

        // R3: no strobe yet, input far from zero, output must stay mid
        expect_win("R3", 786432, 2.0, 2.0, 1'b1, 4, 64);
        strobe_en = 1'b1;

        // R7 and R6: DC accuracy with scrambled data between strobes
        foreach (smp_list[i]) begin
            real e;
            e = 2.0 + real'(smp_list[i]) / QV;
            expect_win("R7", smp_list[i], e - TOL, e + TOL, 1'b0, 1024, 2048);
        end
        expect_win("R6", 393216, 2.75 - TOL, 2.75 + TOL, 1'b0, 1024, 2048);

        // R8: overload at both limits, then recovery
        expect_win("R8", 1048575, 3.9, 4.0, 1'b0, 1024, 2048);
        expect_win("R8", -1048576, 0.0, 0.1, 1'b0, 1024, 2048);
        expect_win("R8", 131072, 2.25 - TOL, 2.25 + TOL, 1'b0, 4096, 2048);

        // R2: mute forces mid, then cleared loop stays exactly mid on zero input
        cur_sample = 629146;
        repeat (500) @(negedge clk);
        mute_i = 1'b1;
        expect_win("R2", 629146, 2.0, 2.0, 1'b1, 4, 64);
        cur_sample = 0;
        mute_i = 1'b0;
        expect_win("R2", 0, 2.0, 2.0, 1'b1, 0, 512);

        // R5: stall the step enable, the code must hold
        cur_sample = 262144;
        repeat (500) @(negedge clk);
        ce_en = 1'b0;
        repeat (2) @(negedge clk);
        c0 = code_o;
        repeat (20) @(negedge clk);
        chk(code_o == c0, "R5", "code during stall", real'(code_o), real'(c0));
        ce_en = 1'b1;

        chk(gmax <= 4, "R4", "largest code seen", real'(gmax), 4.0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule